// File: doc/BRIEF.md
# Zero-Page Address Generator

This block builds the memory address for a small word-addressed processor. It holds four address registers. Register 0 is the program counter and register 1 is the workspace pointer. Each address register has a 4-bit page register beside it. Every cycle the block turns the current instruction fields and phase into a 16-bit address. It also produces a side copy of the chosen register, which the arithmetic unit uses as an operand.

There are three ways to form the address. In the fetch phase the program counter drives the address unchanged. In normal mode a 2-bit select picks a register, and its page value, ORed with the 4-bit displacement, replaces address bits 7..4. In zero-page mode the workspace pointer gives bits 15..8, and the instruction fields fill the low byte. This gives 64 word slots, plus a second bank of 64 slots for jump vectors when the destination is the PC or data register 0.

An active-low hold input releases the address outputs so that another master can reach memory. The registers are written through a plain indexed port that shares one data bus.

Top module: `zpg_addr_gen`

## Requirements
- R1: After reset all four address registers and all four page registers are zero, so every address formed from them is built only from instruction fields.
- R2: When `reg_we` is 1 at a rising edge, `wr_data` is stored in address register `wr_idx`. The new value is visible from the next cycle, and the other registers keep their values.
- R3: When `page_we` is 1 at a rising edge, `wr_data[3:0]` is stored in the page register `wr_idx`, and the address registers are unchanged.
- R4: When `fetch` is 1, `addr_out` equals register 0 exactly. The select, zero-page flag, displacement and page values have no effect on it.
- R5: In normal mode (`fetch`=0, `ir_zp`=0), `addr_out` has bits 15..8 and 3..0 from register `ir_sel`, and bits 7..4 equal to page[`ir_sel`] OR `ir_disp`.
- R6: In zero-page mode (`fetch`=0, `ir_zp`=1), `addr_out` bits 15..8 come from register 1 whatever `ir_sel` is. Bits 7..4 equal `ir_disp`, bit 3 equals `dst_vec`, bit 2 equals `ir_sel[1]`, bit 1 equals `ir_sel[0]` and bit 0 is 0. The page registers have no effect in this mode.
- R7: `side_out` equals the register that drives the address (register 0 in fetch, register 1 in zero-page mode, register `ir_sel` otherwise), with bit 0 forced to 1 when `ir_disp[1]` is 1.
- R8: `mem_rd` is 1 whenever `fetch` is 1. Outside fetch it is 1 exactly when `ir_store` is 0.
- R9: When `bus_hold_n` is 0, `addr_drive` is 0 and `addr_out` is all zeros. When `bus_hold_n` is 1, `addr_drive` is 1. The hold has no effect on stored register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Address register write strobe |
| page_we | input | 1 | Page register write strobe |
| wr_idx | input | 2 | Register index for either write |
| wr_data | input | 16 | Shared write data bus |
| fetch | input | 1 | 1 during the instruction fetch phase |
| ir_sel | input | 2 | Address register select field |
| ir_zp | input | 1 | Zero-page mode flag |
| ir_disp | input | 4 | Displacement field |
| dst_vec | input | 1 | Destination is the PC or data register 0 |
| ir_store | input | 1 | Instruction stores to memory |
| bus_hold_n | input | 1 | Active-low release of the address outputs |
| addr_out | output | 16 | Memory address |
| addr_drive | output | 1 | 1 when the address outputs are driven |
| mem_rd | output | 1 | Memory read request |
| side_out | output | 16 | Register copy for the operand path, with increment-by-two bit |

## Verification
The assertions check several things on every cycle. Fetch always requests a read and suppresses the select and zero-page flag. A zero-page address is always even and carries the select and displacement fields in their slots. The hold always zeroes and releases the address. The side copy always matches the register that was read, with bit 0 set when needed. The stored register contents and page values, the exact merge of page and displacement, and the rule that unselected registers and page registers have no effect can only be shown by the bench's sweeps, which compare every output against values worked out from registers the bench itself loaded.

// File: rtl/zpg_pkg.sv
package zpg_pkg;
  parameter int ADDR_W   = 16;
  parameter int SEL_W    = 2;
  parameter int DISP_W   = 4;
  parameter int INC2_BIT = 1;
  localparam int NREG    = 1 << SEL_W;
  localparam int PG_LSB  = SEL_W + 2;
  localparam int WP_LSB  = PG_LSB + DISP_W;
  localparam int PC_IDX  = 0;
  localparam int WP_IDX  = 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [DISP_W-1:0] disp_t;

  // Register-indirect address: page OR displacement overlays one nibble.
  function automatic addr_t norm_addr(addr_t r, disp_t pg, disp_t d);
    addr_t a;
    a = r;
    a[PG_LSB +: DISP_W] = pg | d;
    return a;
  endfunction

  // Zero-page address: workspace base on top, instruction fields below.
  function automatic addr_t zp_addr(addr_t wp, sel_t s, logic v, disp_t d);
    addr_t a;
    a = '0;
    a[ADDR_W-1:WP_LSB]  = wp[ADDR_W-1:WP_LSB];
    a[PG_LSB +: DISP_W] = d;
    a[SEL_W+1]          = v;
    a[SEL_W:1]          = s;
    return a;
  endfunction

  // Operand copy with bit 0 forced for increment-by-two.
  function automatic addr_t side_val(addr_t r, logic force_lsb);
    addr_t a;
    a = r;
    a[0] = r[0] | force_lsb;
    return a;
  endfunction
endpackage

// File: rtl/zpg_regfile.sv
module zpg_regfile
  import zpg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reg_we,
  input  logic  page_we,
  input  sel_t  wr_idx,
  input  addr_t wr_data,
  input  sel_t  rd_idx,
  output addr_t rd_val,
  output disp_t pg_val
);
  addr_t regs_q  [NREG];
  disp_t pages_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g]  <= '0;
        pages_q[g] <= '0;
      end else begin
        if (reg_we && wr_idx == sel_t'(g))
          regs_q[g] <= wr_data;
        if (page_we && wr_idx == sel_t'(g))
          pages_q[g] <= wr_data[DISP_W-1:0];
      end
    end
  end

  assign rd_val = regs_q[rd_idx];
  assign pg_val = pages_q[rd_idx];
endmodule

// File: rtl/zpg_mode_ctl.sv
module zpg_mode_ctl
  import zpg_pkg::*;
(
  input  logic fetch,
  input  sel_t ir_sel,
  input  logic ir_zp,
  input  logic ir_store,
  output sel_t eff_sel,
  output logic eff_zp,
  output sel_t rd_idx,
  output logic mem_rd
);
  always_comb begin
    eff_sel = fetch ? sel_t'(PC_IDX) : ir_sel;
    eff_zp  = fetch ? 1'b0 : ir_zp;
    rd_idx  = eff_zp ? sel_t'(WP_IDX) : eff_sel;
    mem_rd  = fetch | ~ir_store;
  end
endmodule

// File: rtl/zpg_addr_mux.sv
module zpg_addr_mux
  import zpg_pkg::*;
(
  input  logic  fetch,
  input  logic  eff_zp,
  input  sel_t  eff_sel,
  input  addr_t rd_val,
  input  disp_t pg_val,
  input  disp_t ir_disp,
  input  logic  dst_vec,
  input  logic  bus_hold_n,
  output addr_t addr_out,
  output logic  addr_drive,
  output addr_t side_out
);
  addr_t raw_addr;

  always_comb begin
    if (fetch)       raw_addr = rd_val;
    else if (eff_zp) raw_addr = zp_addr(rd_val, eff_sel, dst_vec, ir_disp);
    else             raw_addr = norm_addr(rd_val, pg_val, ir_disp);
    addr_drive = bus_hold_n;
    addr_out   = bus_hold_n ? raw_addr : '0;
    side_out   = side_val(rd_val, ir_disp[INC2_BIT]);
  end
endmodule

// File: rtl/zpg_addr_gen.sv
module zpg_addr_gen
  import zpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              page_we,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              fetch,
  input  logic [SEL_W-1:0]  ir_sel,
  input  logic              ir_zp,
  input  logic [DISP_W-1:0] ir_disp,
  input  logic              dst_vec,
  input  logic              ir_store,
  input  logic              bus_hold_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_drive,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] side_out
);
  sel_t  eff_sel;
  logic  eff_zp;
  sel_t  rd_idx;
  addr_t rd_val;
  disp_t pg_val;

  zpg_mode_ctl u_ctl (
    .fetch(fetch), .ir_sel(ir_sel), .ir_zp(ir_zp), .ir_store(ir_store),
    .eff_sel(eff_sel), .eff_zp(eff_zp), .rd_idx(rd_idx), .mem_rd(mem_rd)
  );

  zpg_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .page_we(page_we),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_val(rd_val), .pg_val(pg_val)
  );

  zpg_addr_mux u_mux (
    .fetch(fetch), .eff_zp(eff_zp), .eff_sel(eff_sel), .rd_val(rd_val),
    .pg_val(pg_val), .ir_disp(ir_disp), .dst_vec(dst_vec),
    .bus_hold_n(bus_hold_n), .addr_out(addr_out), .addr_drive(addr_drive),
    .side_out(side_out)
  );
endmodule

// File: rtl/zpg_addr_gen_chk.sv
module zpg_addr_gen_chk
  import zpg_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  fetch,
  input sel_t  ir_sel,
  input disp_t ir_disp,
  input logic  dst_vec,
  input logic  bus_hold_n,
  input addr_t addr_out,
  input logic  addr_drive,
  input logic  mem_rd,
  input addr_t side_out,
  input sel_t  eff_sel,
  input logic  eff_zp,
  input addr_t rd_val
);
  a_r8_fetch_reads: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> mem_rd);

  a_r4_fetch_forces_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (eff_sel == sel_t'(PC_IDX) && !eff_zp));

  a_r4_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && bus_hold_n) |-> addr_out == rd_val);

  a_r6_zp_even: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_zp && bus_hold_n) |-> !addr_out[0]);

  a_r6_zp_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_zp && bus_hold_n) |-> (addr_out[SEL_W:1] == ir_sel
      && addr_out[PG_LSB +: DISP_W] == ir_disp && addr_out[SEL_W+1] == dst_vec));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hold_n |-> (addr_out == '0 && !addr_drive));

  a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold_n |-> addr_drive);

  a_r7_side_copy: assert property (@(posedge clk) disable iff (!rst_n)
    side_out[ADDR_W-1:1] == rd_val[ADDR_W-1:1]
      && side_out[0] == (rd_val[0] | ir_disp[INC2_BIT]));
endmodule

bind zpg_addr_gen zpg_addr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fetch(fetch), .ir_sel(ir_sel), .ir_disp(ir_disp),
  .dst_vec(dst_vec), .bus_hold_n(bus_hold_n), .addr_out(addr_out),
  .addr_drive(addr_drive), .mem_rd(mem_rd), .side_out(side_out),
  .eff_sel(eff_sel), .eff_zp(eff_zp), .rd_val(rd_val)
);

// File: tb/zpg_addr_gen_tb.sv
module zpg_addr_gen_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, page_we = 0;
  logic [1:0]  wr_idx = 0;
  logic [15:0] wr_data = 0;
  logic        fetch = 0, ir_zp = 0, dst_vec = 0, ir_store = 0, bus_hold_n = 1;
  logic [1:0]  ir_sel = 0;
  logic [3:0]  ir_disp = 0;
  logic [15:0] addr_out, side_out;
  logic        addr_drive, mem_rd;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] m_reg [4];
  logic [3:0]  m_pg  [4];

  always #(PERIOD/2) clk = ~clk;

  zpg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .page_we(page_we),
    .wr_idx(wr_idx), .wr_data(wr_data), .fetch(fetch), .ir_sel(ir_sel),
    .ir_zp(ir_zp), .ir_disp(ir_disp), .dst_vec(dst_vec), .ir_store(ir_store),
    .bus_hold_n(bus_hold_n), .addr_out(addr_out), .addr_drive(addr_drive),
    .mem_rd(mem_rd), .side_out(side_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (sel=%0d zp=%0d f=%0d d=%h v=%0d)",
               req, act, exp, ir_sel, ir_zp, fetch, ir_disp, dst_vec);
    end
  endtask

  task automatic wr(bit page, int idx, logic [15:0] val);
    @(negedge clk);
    reg_we = !page; page_we = page; wr_idx = idx[1:0]; wr_data = val;
    @(negedge clk);
    reg_we = 0; page_we = 0; wr_data = 16'hDEAD;
    if (page) m_pg[idx] = val[3:0]; else m_reg[idx] = val;
  endtask

  // Expected address computed arithmetically from the requirements.
  function automatic logic [15:0] exp_addr();
    int src;
    if (!bus_hold_n) return 16'h0;                                   // R9
    if (fetch) return m_reg[0];                                      // R4
    if (ir_zp)                                                       // R6
      return (m_reg[1] & 16'hFF00) + 16'(ir_disp) * 16 + 16'(dst_vec) * 8
             + 16'(ir_sel) * 2;
    src = ir_sel;                                                    // R5
    return (m_reg[src] & 16'hFF0F) | (16'(m_pg[src] | ir_disp) << 4);
  endfunction

  function automatic logic [15:0] exp_side();
    int src;
    src = fetch ? 0 : (ir_zp ? 1 : int'(ir_sel));
    return m_reg[src] | (ir_disp[1] ? 16'h1 : 16'h0);                // R7
  endfunction

  task automatic sweep();
    for (int s = 0; s < 4; s++)
      for (int z = 0; z < 2; z++)
        for (int f = 0; f < 2; f++)
          for (int d = 0; d < 16; d++)
            for (int v = 0; v < 2; v++)
              for (int h = 0; h < 2; h++) begin
                @(negedge clk);
                ir_sel = s[1:0]; ir_zp = z[0]; fetch = f[0]; ir_disp = d[3:0];
                dst_vec = v[0]; bus_hold_n = h[0]; ir_store = (d % 3) == 0;
                #1;
                chk(fetch ? "R4" : (ir_zp ? "R6" : "R5"), addr_out, exp_addr());
                chk("R9", {15'h0, addr_drive}, {15'h0, bus_hold_n});
                chk("R8", {15'h0, mem_rd}, {15'h0, fetch | ~ir_store});
                chk("R7", side_out, exp_side());
              end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_reg[i] = 0; m_pg[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state observed through each read path
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ir_sel = i[1:0]; ir_zp = 0; fetch = 0; ir_disp = 0;
      #1; chk("R1", addr_out, 16'h0); chk("R1", side_out, 16'h0);
    end
    sweep();
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 4; i++) begin
        wr(0, i, 16'(16'h1357 * (k + 1) + i * 16'h2481 + k));        // R2
        wr(1, i, 16'((i * 5 + k * 3) | 16'hFFF0));                    // R3
      end
      // R2: a write to one register leaves the others unchanged
      @(negedge clk); fetch = 0; ir_zp = 0; ir_disp = 0; bus_hold_n = 1;
      for (int i = 0; i < 4; i++) begin
        ir_sel = i[1:0]; #1;
        chk("R2", addr_out, (m_reg[i] & 16'hFF0F) | (16'(m_pg[i]) << 4));
        @(negedge clk);
      end
      // R3: page write leaves address register value intact (bit 0 path)
      wr(1, 2, 16'h0000);
      @(negedge clk); ir_sel = 2; ir_disp = 0; #1;
      chk("R3", side_out, m_reg[2]);
      sweep();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule